// File: doc/BRIEF.md
# Fixed-Point Newton-Raphson Reciprocal Unit

This unit computes the reciprocal of a positive fixed-point operand. The operand and the result share one 24-bit layout. Bit 23 is the sign, bits 22..16 hold the integer part and bits 15..0 hold the fraction. A softmax stage uses the unit to turn the sum of its exponentials into a scale factor. The client pulses `start` with the operand on `den`. The unit reports `busy` while it works, and it raises `done` for one cycle when `quot` carries the new value.

The initial estimate comes from shift logic and needs no table. The position of the operand's highest set bit picks the estimate. The unit then refines the estimate with exactly three Newton-Raphson passes of the form x ← x·(2 − d·x). Each pass keeps full-precision products and truncates back to 16 fraction bits. A zero operand skips the passes and returns the largest positive value.

Top module: `recip_nr`

## Requirements
- R1: After reset, `busy`, `done` and `quot` are all 0.
- R2: A `start` pulse with a nonzero operand, sampled while idle, makes `busy` high for exactly three cycles. `done` is high for one cycle in the cycle right after the last busy cycle, and `quot` holds the result in that cycle.
- R3: A `start` sampled while `busy` is high is ignored. It does not change the operand in use, the timing or the result.
- R4: When the operand is 2.0 or more, its highest set bit is at position 16+k with k ≥ 1. The estimate is then 2^−(k+1), a single set bit at fraction position 15−k.
- R5: When bit 16 is the highest set bit and bit 15 is also set (1.5 ≤ d < 2), the estimate is 0.5, encoded as 0x008000.
- R6: When the operand is below 1.5 (highest set bit below 16, or bit 16 set and bit 15 clear), the estimate is 1.0, encoded as 0x010000.
- R7: Each of the three passes computes d·x, subtracts it from 2.0 and multiplies the difference by x, all at full width. The unit then drops the low 32 bits of the product to return to 16 fraction bits. Examples: 1.0 → 0x010000, 2.0 → 0x007F80, 1.5 → 0x00AAAA.
- R8: An operand whose magnitude bits (22..0) are zero gives `quot` = 0x7FFFFF with `done` high in the next cycle, and `busy` stays low.
- R9: Bit 23 of `quot` is always 0, and the input sign bit has no effect on the result. `quot` changes only in a cycle where `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request pulse, sampled only while idle |
| den | input | 24 | Operand, Q7.16 with sign bit 23 |
| busy | output | 1 | Refinement in progress |
| done | output | 1 | One-cycle pulse marking a new result |
| quot | output | 24 | Reciprocal, Q7.16, sign bit always 0 |

## Verification
Three operands have exact results that are checked against hand-derived constants. Exactly 1.0 stays at the seed. Exactly 2.0 exercises the shifted seed for k = 1. Exactly 1.5 exercises the 0.5 seed and confirms the truncation rule.

Further operands are compared cycle by cycle against a behavioural model. A very small fraction, values between 1 and 2 on both sides of 1.5, and large integers up to the full magnitude range separate the three seed branches and each leading-one position. A zero operand checks the bypass. A held or repeated `start` during a run shows that requests are not taken mid-computation. An operand with its sign bit set shows that the sign is ignored.

// File: rtl/recip_nr.sv
module recip_nr #(
  parameter int W     = 24,
  parameter int FRAC  = 16,
  parameter int ITERS = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] den,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quot
);
  localparam int MW = W - 1;
  localparam int PW = 2 * W + FRAC;
  localparam int CW = $clog2(ITERS + 1);

  logic [MW-1:0] d_q, x_q, seed, x_nx;
  logic [CW-1:0] cnt_q;
  logic [PW-1:0] dx, corr, prod;
  int            lead;

  always_comb begin
    lead = 0;
    for (int i = 0; i < MW; i++)
      if (den[i]) lead = i;
  end

  always_comb begin
    if (lead > FRAC)
      seed = MW'(1) << (2 * FRAC - 1 - lead);
    else if (lead == FRAC && den[FRAC-1])
      seed = MW'(1) << (FRAC - 1);
    else
      seed = MW'(1) << FRAC;
  end

  assign dx   = PW'(d_q) * PW'(x_q);
  assign corr = (PW'(2) << (2 * FRAC)) - dx;
  assign prod = PW'(x_q) * corr;
  assign x_nx = MW'(prod >> (2 * FRAC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      quot  <= '0;
      d_q   <= '0;
      x_q   <= '0;
      cnt_q <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          if (den[MW-1:0] == '0) begin
            quot <= {1'b0, {MW{1'b1}}};
            done <= 1'b1;
          end else begin
            d_q   <= den[MW-1:0];
            x_q   <= seed;
            cnt_q <= '0;
            busy  <= 1'b1;
          end
        end
      end else begin
        x_q   <= x_nx;
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CW'(ITERS - 1)) begin
          busy <= 1'b0;
          done <= 1'b1;
          quot <= {1'b0, x_nx};
        end
      end
    end
  end
endmodule

// File: rtl/recip_nr_chk.sv
module recip_nr_chk #(
  parameter int W     = 24,
  parameter int ITERS = 3
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] quot
);
  int run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_len <= 0;
    else if (busy) run_len <= run_len + 1;
    else run_len <= 0;
  end

  p_sign_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    quot[W-1] == 1'b0);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(quot) |-> done);

  p_busy_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> run_len < ITERS);

  p_done_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done && run_len == ITERS));

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_no_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && run_len < ITERS - 1) |=> busy);
endmodule

bind recip_nr recip_nr_chk #(.W(W), .ITERS(ITERS)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start),
  .busy(busy), .done(done), .quot(quot)
);

// File: tb/recip_nr_tb_top.sv
`timescale 1ns/1ps
module recip_nr_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [23:0] den = '0;
  logic        busy, done;
  logic [23:0] quot;
  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  recip_nr dut_i (.clk(clk), .rst_n(rst_n), .start(start), .den(den),
                  .busy(busy), .done(done), .quot(quot));

  // behavioural reference
  logic        m_busy, m_done;
  logic [23:0] m_q;
  longint unsigned m_d, m_x;
  int m_left;

  function automatic longint unsigned seed_of(longint unsigned d);
    int top = 0;
    for (int i = 0; i < 23; i++) if (d[i]) top = i;
    if (d >= 64'h20000) return 64'd1 << (15 - (top - 16));
    if (d >= 64'h18000) return 64'h8000;
    return 64'h10000;
  endfunction

  function automatic longint unsigned step(longint unsigned d, longint unsigned x);
    longint unsigned t = (64'd2 << 32) - d * x;
    return (x * t) >> 32;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_q = 0; m_left = 0; m_d = 0; m_x = 0;
    end else begin
      m_done = 0;
      if (!m_busy) begin
        if (start) begin
          if (den[22:0] == 0) begin m_q = 24'h7FFFFF; m_done = 1; end
          else begin
            m_d = 64'(den[22:0]); m_x = seed_of(m_d); m_left = 3; m_busy = 1;
          end
        end
      end else begin
        m_x = step(m_d, m_x);
        m_left--;
        if (m_left == 0) begin m_busy = 0; m_done = 1; m_q = 24'(m_x); end
      end
    end
  end

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R2 busy vs model", 32'(busy), 32'(m_busy));
      check("R2 done vs model", 32'(done), 32'(m_done));
      check("R7 quot vs model", 32'(quot), 32'(m_q));
      check("R9 sign clear", 32'(quot[23]), 32'd0);
    end
  end

  task automatic run(logic [23:0] d, int hold);
    @(negedge clk);
    start = 1'b1; den = d;
    repeat (hold) @(negedge clk);
    start = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic finish_up();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy reset", 32'(busy), 0);
    check("R1 done reset", 32'(done), 0);
    check("R1 quot reset", 32'(quot), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run(24'h010000, 1); check("R6 r7_ one", 32'(quot), 32'h010000);
    run(24'h020000, 1); check("R4 r7_ two", 32'(quot), 32'h007F80);
    run(24'h018000, 1); check("R5 r7_ one and half", 32'(quot), 32'h00AAAA);
    run(24'h000000, 1); check("R8 zero", 32'(quot), 32'h7FFFFF);
    run(24'h810000, 1); check("R9 sign ignored", 32'(quot), 32'h010000);

    // R3: start held through the run with the same operand
    @(negedge clk); start = 1'b1; den = 24'h020000;
    @(negedge clk); den = 24'h010000;
    @(negedge clk); @(negedge clk);
    start = 1'b0;
    check("R3 busy kept", 32'(busy), 1);
    @(negedge clk);
    check("R3 done", 32'(done), 1);
    check("R3 first operand used", 32'(quot), 32'h007F80);
    repeat (4) @(negedge clk);

    run(24'h000100, 1);
    run(24'h014000, 1);
    run(24'h01C000, 1);
    run(24'h017FFF, 1);
    run(24'h030000, 1);
    run(24'h040000, 1);
    run(24'h123456, 1);
    run(24'h7FFFFF, 1);
    run(24'h400000, 1);
    run(24'h00C000, 1);
    run(24'h000000, 3);
    run(24'h050000, 8);
    finish_up();
  end
endmodule